// File: doc/BRIEF.md
# Fractional-N Divide Controller

This block is the digital half of a fractional-N synthesizer feedback path. It is clocked by the output of an external 8/9 dual-modulus prescaler. For every feedback period it picks an instantaneous divide value N' and drives the prescaler's modulus control so that the VCO is divided by exactly N'. At the end of the period it emits one divided pulse for the phase detector.

N' is the programmed integer N plus a carry from a first-order modulo-D accumulator. D is one of three non-power-of-two denominators selected at run time. Over D feedback periods the average division is N + F/D. With a 26 MHz comparison reference and D = 1040, one fraction step is 25 kHz.

Configuration words are captured on a load strobe. They take effect only at a feedback-period boundary, so no period is ever split between two settings.

Top module: `frac_div_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first loaded configuration is applied, `mod9_o` and `div_o` are both low.
- R2: `n_int_i`, `frac_i` and `den_sel_i` are captured on a `pre_clk_i` rising edge where `load_i` is high. The select encoding is 0→D=1040, 1→D=1170, 2→D=1235 and 3→D=1040.
- R3: A feedback period with divide value N' lasts N'>>3 prescaler pulses. `mod9_o` is high (divide-by-9) for the first N'&7 of those pulses and low (divide-by-8) for the rest. `div_o` is high during exactly the last pulse of the period.
- R4: Each period's divide value is computed as follows. The accumulator adds F. If the sum is at least D, D is subtracted and N' = N+1; otherwise N' = N. When a new configuration is applied, the accumulator restarts from 0.
- R5: Over the D consecutive periods that follow an application, exactly F periods use N+1 and the rest use N.
- R6: A captured fraction F ≥ D is clamped to D−1.
- R7: F = 0 yields N' = N in every period.
- R8: A captured configuration is applied at the next period boundary. The period in progress, including one that begins on the capture edge, completes with the old values. Input changes without `load_i` have no effect.
- R9: N must lie in 56..2^NW−2, so that the swallow count never exceeds the main count (A ≤ M).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pre_clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Configuration capture strobe |
| n_int_i | input | NW | Integer divide value N |
| frac_i | input | 11 | Fraction numerator F |
| den_sel_i | input | 2 | Denominator select |
| mod9_o | output | 1 | 1 = prescaler divides by 9, 0 = by 8 |
| div_o | output | 1 | Divided feedback pulse, one prescaler period wide |

## Verification
The bench builds the block with its default NW = 8. Integer values from 56 to 71 then give feedback periods of only seven to nine prescaler pulses. This short period makes it affordable to walk every one of the D periods of a full accumulator cycle for all three denominators and for the aliased select code. Each period is checked against an arithmetic accumulator model. The N values are chosen so that N+1 crosses an octave (63→64, 71→72), which checks the case where the swallow count wraps to zero. Separate runs cover the maximum fraction, the clamp, F = 0, and a reload issued on a boundary edge.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned FW   = 11;
  localparam int unsigned DEN0 = 1040;
  localparam int unsigned DEN1 = 1170;
  localparam int unsigned DEN2 = 1235;

  function automatic logic [FW-1:0] den_of(input logic [1:0] sel);
    case (sel)
      2'd1:    den_of = FW'(DEN1);
      2'd2:    den_of = FW'(DEN2);
      default: den_of = FW'(DEN0);
    endcase
  endfunction
endpackage

// File: rtl/fd_cfg.sv
module fd_cfg import frac_div_pkg::*; #(
  parameter int unsigned NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NW-1:0] n_i,
  input  logic [FW-1:0] f_i,
  input  logic [1:0]    sel_i,
  input  logic          boundary_i,
  output logic [NW-1:0] n_o,
  output logic [FW-1:0] f_o,
  output logic [FW-1:0] d_o,
  output logic          apply_o,
  output logic          valid_o
);
  logic          pend_q, act_q;
  logic [NW-1:0] pend_n_q, act_n_q;
  logic [FW-1:0] pend_f_q, act_f_q, pend_d_q, act_d_q;
  logic [FW-1:0] den_in, f_clamp;

  assign den_in  = den_of(sel_i);
  assign f_clamp = (f_i >= den_in) ? den_in - FW'(1) : f_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      act_q    <= 1'b0;
      pend_n_q <= '0;
      act_n_q  <= '0;
      pend_f_q <= '0;
      act_f_q  <= '0;
      pend_d_q <= FW'(DEN0);
      act_d_q  <= FW'(DEN0);
    end else begin
      if (boundary_i && pend_q) begin
        act_q   <= 1'b1;
        act_n_q <= pend_n_q;
        act_f_q <= pend_f_q;
        act_d_q <= pend_d_q;
      end
      if (load_i) begin
        pend_q   <= 1'b1;
        pend_n_q <= n_i;
        pend_f_q <= f_clamp;
        pend_d_q <= den_in;
      end else if (boundary_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign n_o     = pend_q ? pend_n_q : act_n_q;
  assign f_o     = pend_q ? pend_f_q : act_f_q;
  assign d_o     = pend_q ? pend_d_q : act_d_q;
  assign apply_o = pend_q;
  assign valid_o = pend_q | act_q;

  // R6
  pend_f_lt_d_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> pend_f_q < pend_d_q);
  // R8
  hold_without_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(boundary_i && pend_q)) |=> $stable(act_n_q) && $stable(act_f_q));
endmodule

// File: rtl/fd_sdm.sv
module fd_sdm import frac_div_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          clear_i,
  input  logic [FW-1:0] f_i,
  input  logic [FW-1:0] d_i,
  output logic          carry_o
);
  logic [FW-1:0] acc_q, base;
  logic [FW:0]   sum, nxt;

  assign base    = clear_i ? '0 : acc_q;
  assign sum     = {1'b0, base} + {1'b0, f_i};
  assign carry_o = sum >= {1'b0, d_i};
  assign nxt     = carry_o ? sum - {1'b0, d_i} : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= nxt[FW-1:0];
  end

  // R4
  acc_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> acc_q < $past(d_i));
endmodule

// File: rtl/fd_swallow.sv
module fd_swallow #(
  parameter int unsigned NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NW-1:0] n_i,
  output logic          boundary_o,
  output logic          mod9_o,
  output logic          div_o
);
  localparam int unsigned MW = NW - 3;

  logic          run_q;
  logic [NW-1:0] n_q;
  logic [MW-1:0] cnt_q, m_cnt, a_cnt;
  logic          last;

  assign m_cnt      = n_q[NW-1:3];
  assign a_cnt      = MW'(n_q[2:0]);
  assign last       = run_q && (cnt_q == m_cnt - MW'(1));
  assign boundary_o = !run_q || last;
  assign mod9_o     = run_q && (cnt_q < a_cnt);
  assign div_o      = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      n_q   <= '0;
      cnt_q <= '0;
    end else if (boundary_o) begin
      cnt_q <= '0;
      run_q <= load_i;
      if (load_i) n_q <= n_i;
    end else begin
      cnt_q <= cnt_q + MW'(1);
    end
  end

  // R9
  a_le_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> a_cnt <= m_cnt);
  // R3
  div_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);
  // R3
  mod9_front_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !boundary_o && !mod9_o) |=> !mod9_o);
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl import frac_div_pkg::*; #(
  parameter int unsigned NW = 8
) (
  input  logic          pre_clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NW-1:0] n_int_i,
  input  logic [FW-1:0] frac_i,
  input  logic [1:0]    den_sel_i,
  output logic          mod9_o,
  output logic          div_o
);
  logic          boundary, apply, cfg_valid, carry;
  logic [NW-1:0] n_eff, n_next;
  logic [FW-1:0] f_eff, d_eff;

  fd_cfg #(.NW(NW)) i_cfg (
    .clk_i(pre_clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .n_i(n_int_i), .f_i(frac_i), .sel_i(den_sel_i),
    .boundary_i(boundary), .n_o(n_eff), .f_o(f_eff), .d_o(d_eff),
    .apply_o(apply), .valid_o(cfg_valid)
  );

  fd_sdm i_sdm (
    .clk_i(pre_clk_i), .rst_ni(rst_ni), .step_i(boundary && cfg_valid),
    .clear_i(apply), .f_i(f_eff), .d_i(d_eff), .carry_o(carry)
  );

  assign n_next = n_eff + NW'(carry);

  fd_swallow #(.NW(NW)) i_swallow (
    .clk_i(pre_clk_i), .rst_ni(rst_ni), .load_i(cfg_valid),
    .n_i(n_next), .boundary_o(boundary), .mod9_o(mod9_o), .div_o(div_o)
  );

  // R7
  zero_frac_no_carry_chk: assert property (@(posedge pre_clk_i) disable iff (!rst_ni)
    (boundary && cfg_valid && f_eff == '0) |-> !carry);
  // R1
  idle_quiet_chk: assert property (@(posedge pre_clk_i) disable iff (!rst_ni)
    !cfg_valid |-> !mod9_o && !div_o);
endmodule

// File: tb/test_frac_div_ctrl.sv
module test_frac_div_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic pre_clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic [NW-1:0] n_int_i = '0;
  logic [10:0] frac_i = '0;
  logic [1:0] den_sel_i = '0;
  logic mod9_o, div_o;

  int n_chk = 0;
  int n_fail = 0;
  int acc_m, n_m, f_m, d_m;

  frac_div_ctrl #(.NW(NW)) i_frac_div_ctrl (
    .pre_clk_i(pre_clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .n_int_i(n_int_i), .frac_i(frac_i), .den_sel_i(den_sel_i),
    .mod9_o(mod9_o), .div_o(div_o)
  );

  always #(CLK_PERIOD/2) pre_clk_i = ~pre_clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int den_exp(input int sel);
    case (sel)
      1: return 1170;
      2: return 1235;
      default: return 1040;
    endcase
  endfunction

  // returns next N' from the model and advances it
  function automatic int model_step();
    int s = acc_m + f_m;
    if (s >= d_m) begin acc_m = s - d_m; return n_m + 1; end
    acc_m = s;
    return n_m;
  endfunction

  task automatic measure(output int len, output int n9);
    len = 0; n9 = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge pre_clk_i);
      load_i = 1'b0;
      len++;
      if (mod9_o) n9++;
      if (div_o) return;
    end
    chk(1'b0, "R3 period timeout", len, 0);
  endtask

  // one period checked against model; returns 1 if N+1 was used
  task automatic period_chk(input string tag, output bit up);
    int len, n9, np;
    np = model_step();
    up = (np != n_m);
    measure(len, n9);
    chk(len == (np >> 3), {"R3 length ", tag}, len, np >> 3);
    chk(n9 == (np & 7), {"R3/R4 div9 count ", tag}, n9, np & 7);
  endtask

  task automatic do_reset();
    @(negedge pre_clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge pre_clk_i);
    chk(!mod9_o && !div_o, "R1 in reset", {mod9_o, div_o}, 0);
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge pre_clk_i);
      chk(!mod9_o && !div_o, "R1 idle before load", {mod9_o, div_o}, 0);
    end
  endtask

  task automatic run_cfg(input int n, input int f, input int sel, input int n_per);
    int ups = 0;
    bit up;
    do_reset();
    n_int_i = NW'(n); frac_i = 11'(f); den_sel_i = 2'(sel);
    load_i = 1'b1;
    @(negedge pre_clk_i);
    load_i = 1'b0;
    n_m = n; d_m = den_exp(sel); f_m = (f >= d_m) ? d_m - 1 : f; acc_m = 0;
    for (int i = 0; i < n_per; i++) begin
      period_chk("R2", up);
      if (up) ups++;
    end
    if (n_per == d_m) chk(ups == f_m, "R5/R6/R7 carries over D", ups, f_m);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit up;
    run_cfg(63, 1, 0, 1040);      // R5: 25 kHz step, octave crossing
    run_cfg(71, 1234, 2, 1235);   // R5: maximum fraction
    run_cfg(56, 0, 3, 1040);      // R7, R2 select 3 aliases 1040
    run_cfg(60, 2000, 0, 1040);   // R6 clamp to 1039
    run_cfg(60, 585, 1, 1170);    // R5 half step on 1170
    // R8: inputs changed without load are ignored
    n_int_i = 8'd63; frac_i = 11'd100; den_sel_i = 2'd2;
    period_chk("R8 no load", up);
    period_chk("R8 no load", up);
    // R8: load on the boundary edge, the started period keeps old values
    load_i = 1'b1;
    period_chk("R8 old period", up);
    n_m = 63; f_m = 100; d_m = 1235; acc_m = 0;
    for (int i = 0; i < 40; i++) period_chk("R8 new config", up);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule